// File: doc/BRIEF.md
# Burst Address Sequencer (Linear / Interleaved)

This block produces the address of each beat of a four-beat memory burst. When the address strobe input is accepted on a rising clock edge, the block captures the whole external address. The two lowest bits become the burst start, and the upper bits are held unchanged for the rest of the burst. On each later edge where the active-low advance input is low, the low bits move to the next beat. When advance is high, they hold (burst suspend).

The beat order is picked by a static order-select input. Low gives a linear order, where beat k is (start + k) mod 4. High gives an interleaved order, where beat k is start XOR k. Both orders wrap after the fourth beat and repeat the same sequence. A strobe in the middle of a burst reloads the block at once. Memory access, chip-enable decoding and write control belong to the surrounding logic.

Top module: `burst_addr_gen`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released with no strobe, `addr_o` is all zeros.
- R2: A strobe (`ld_i` = 1) at a rising edge makes `addr_o` equal to `addr_i` from that edge, starting right after the edge. This is beat 0.
- R3: With `order_i` = 0 (linear), each edge with `adv_n_i` = 0 and no strobe changes the low two bits to (previous + 1) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R4: With `order_i` = 1 (interleaved), beat k has low bits start XOR k. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R5: An edge with `adv_n_i` = 1 and no strobe leaves `addr_o` unchanged, whatever is driven on `addr_i`.
- R6: After the fourth beat, one more advance returns the low bits to the start value, and the same sequence continues.
- R7: When `ld_i` = 1 and `adv_n_i` = 0 at the same edge, the strobe wins. The output becomes beat 0 of the new address, including when a burst is in progress.
- R8: Bits `addr_o[ADDR_W-1:2]` change only at a strobe edge. Advancing never alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Accepted address strobe, active high |
| addr_i | input | ADDR_W | External address captured on a strobe |
| adv_n_i | input | 1 | Advance to next beat, active low |
| order_i | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The hardest case to reach is a strobe that arrives together with advance while a burst is partly done and the beat index is not zero. That case tests both load priority and the reset of the index. The directed part runs a burst to its third beat and then raises the strobe with advance still low. The random part draws strobes at a low rate while advance is mostly low, so reloads land on every beat position in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } beat_order_e;
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int ADDR_W = 17,
  parameter int OFS_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_i,
  input  logic                    adv_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [OFS_W-1:0]        start_q,
  output logic [OFS_W-1:0]        idx_q,
  output logic [ADDR_W-OFS_W-1:0] upper_q
);
  localparam int UP_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] start_d, idx_d;
  logic [UP_W-1:0]  upper_d;
  logic             beat_en;

  assign beat_en = ld_i | ~adv_n_i;

  always_comb begin
    start_d = start_q;
    idx_d   = idx_q;
    upper_d = upper_q;
    if (ld_i) begin
      start_d = addr_i[OFS_W-1:0];
      upper_d = addr_i[ADDR_W-1:OFS_W];
      idx_d   = '0;
    end else if (!adv_n_i) begin
      idx_d = idx_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      idx_q   <= '0;
      upper_q <= '0;
    end else begin
      if (beat_en) idx_q <= idx_d;
      if (ld_i) begin
        start_q <= start_d;
        upper_q <= upper_d;
      end
    end
  end

  // R5
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && adv_n_i) |=> ($stable(idx_q) && $stable(start_q)));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (idx_q == '0 && start_q == $past(addr_i[OFS_W-1:0])));

  // R6
  wrap_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !adv_n_i && idx_q == '1) |=> (idx_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] idx_i,
  input  logic             order_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] lin_ofs, ilv_ofs;
  beat_order_e      ord;

  assign ord = beat_order_e'(order_i);

  genvar b;
  generate
    for (b = 0; b < OFS_W; b++) begin : g_ilv
      assign ilv_ofs[b] = start_i[b] ^ idx_i[b];
    end
  endgenerate

  assign lin_ofs = start_i + idx_i;

  always_comb begin
    unique case (ord)
      ORD_INTERLEAVE: ofs_o = ilv_ofs;
      default:        ofs_o = lin_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFS_W = 2;
  localparam int UP_W  = ADDR_W - OFS_W;

  logic [OFS_W-1:0] start_q, idx_q, ofs;
  logic [UP_W-1:0]  upper_q;

  burst_beat_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (ld_i),
    .adv_n_i (adv_n_i),
    .addr_i  (addr_i),
    .start_q (start_q),
    .idx_q   (idx_q),
    .upper_q (upper_q)
  );

  burst_order_map #(.OFS_W(OFS_W)) u_map (
    .start_i (start_q),
    .idx_i   (idx_q),
    .order_i (order_i),
    .ofs_o   (ofs)
  );

  assign addr_o = {upper_q, ofs};

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(addr_o[ADDR_W-1:OFS_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!order_i && !$past(order_i) && !$past(ld_i) && !$past(adv_n_i))
      |-> (ofs == $past(ofs) + OFS_W'(1)));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_i && $past(order_i) && !$past(ld_i) && !$past(adv_n_i))
      |-> ((ofs ^ start_q) == ($past(idx_q) + OFS_W'(1))));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_i;
  logic [AW-1:0] addr_i;
  logic          adv_n_i;
  logic          order_i;
  logic [AW-1:0] addr_o;

  int total = 0;
  int bad   = 0;

  logic [AW-3:0] m_up;
  logic [1:0]    m_st, m_ix;
  logic          m_ord;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .addr_i(addr_i),
    .adv_n_i(adv_n_i), .order_i(order_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] o;
    o = m_ord ? (m_st ^ m_ix) : (m_st + m_ix);
    return {m_up, o};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_o !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [AW-1:0] a,
                      input logic advn, input logic ord);
    @(negedge clk);
    ld_i = ld; addr_i = a; adv_n_i = advn; order_i = ord;
    m_ord = ord;
    if (ld) begin
      m_up = a[AW-1:2]; m_st = a[1:0]; m_ix = 2'd0;
    end else if (!advn) begin
      m_ix = m_ix + 2'd1;
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; ld_i = 1'b0; addr_i = '0; adv_n_i = 1'b1; order_i = 1'b1;
    m_up = '0; m_st = '0; m_ix = '0; m_ord = 1'b1;
    #3;
    chk("R1 during reset", '0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 17'h1FFFF, 1'b1, 1'b1);
    chk("R1 after release", '0);

    // linear, start 01
    a = 17'h0ABC5;
    step(1'b1, a, 1'b1, 1'b0); chk("R2 load beat0", a);
    step(1'b0, '0, 1'b0, 1'b0); chk("R3 linear beat1", {a[AW-1:2], 2'b10});
    step(1'b0, '0, 1'b0, 1'b0); chk("R3 linear beat2", {a[AW-1:2], 2'b11});
    step(1'b0, '0, 1'b0, 1'b0); chk("R3 linear beat3", {a[AW-1:2], 2'b00});
    step(1'b0, '0, 1'b0, 1'b0); chk("R6 linear wrap", {a[AW-1:2], 2'b01});
    step(1'b0, 17'h1FFFF, 1'b1, 1'b0); chk("R5 hold", {a[AW-1:2], 2'b01});
    step(1'b0, 17'h00000, 1'b1, 1'b0); chk("R8 upper unchanged", {a[AW-1:2], 2'b01});

    // interleaved, start 01
    a = 17'h13579;
    step(1'b1, a, 1'b1, 1'b1); chk("R2 load ilv", a);
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 ilv beat1", {a[AW-1:2], 2'b00});
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 ilv beat2", {a[AW-1:2], 2'b11});
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 ilv beat3", {a[AW-1:2], 2'b10});
    step(1'b0, '0, 1'b0, 1'b1); chk("R6 ilv wrap", {a[AW-1:2], 2'b01});

    // interleaved, start 10, reload mid-burst with advance low
    a = 17'h0F0F2;
    step(1'b1, a, 1'b0, 1'b1); chk("R7 load over advance", a);
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 ilv s10 beat1", {a[AW-1:2], 2'b11});
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 ilv s10 beat2", {a[AW-1:2], 2'b00});
    a = 17'h1C003;
    step(1'b1, a, 1'b0, 1'b1); chk("R7 mid-burst reload", a);
    step(1'b0, '0, 1'b0, 1'b1); chk("R4 after reload", {a[AW-1:2], 2'b10});

    // random
    for (int i = 0; i < 600; i++) begin
      logic ld, advn, ord;
      ld   = ($urandom % 6) == 0;
      advn = ($urandom % 4) == 0;
      ord  = ld ? logic'($urandom % 2) : m_ord;
      step(ld, AW'($urandom), advn, ord);
      if (ld)                chk("R2/R7 random load", model_addr());
      else if (advn)         chk("R5 random hold", model_addr());
      else if (m_ord)        chk("R4 random step", model_addr());
      else                   chk("R3 random step", model_addr());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule